// File: doc/BRIEF.md
# PCIe Power-Up Reset Sequencer

This block brings a PCIe controller and its PHY out of reset in a fixed order and then watches for the link to come up. After a start request it does the following, in order:

- raises the power-on enable;
- turns on the reference clock and then the bus clock, one cycle apart;
- in the shared-power variant only, waits a settling time and then enables the reference-clock output;
- holds the endpoint reset low for a fixed time and then releases it;
- releases the PHY reset;
- waits for the controller to report that its configuration is done;
- raises the link training enable.

It then polls the link-up status at a fixed interval. It ends with either a done flag or a link-fail flag, and that outcome holds until reset.

A variant select is taken when start is accepted. When it is set, the PHY has its own power domain. In that case the PHY reset is forced on from the start and released just before training is enabled, and the reference-clock output is never used. When it is clear, the PHY reset is never driven, and the reference-clock output is enabled after the settling wait.

All delays are given in microseconds and turned into clock cycles with a clock-rate parameter (cycles per microsecond). Every control and status pin is plain and level-driven.

Top module: `pcie_rst_seq`

## Requirements
- R1: After reset, and until start is accepted, every output is 0. This includes `ep_rst_n_o`, so the endpoint is held in reset. An asynchronous reset at any time returns all outputs to this state at once.
- R2: Start is accepted at a rising edge at which `start_i` is 1. `pwr_en_o` rises at that edge. `ref_clk_en_o` rises one cycle later and `bus_clk_en_o` one cycle after that. No clock enable is ever 1 while `pwr_en_o` is 0.
- R3: When the latched variant is 1 (separate PHY power), `phy_rst_o` is 1 from the start edge and falls at the same edge at which `ep_rst_n_o` rises. `ref_out_en_o` stays 0.
- R4: When the latched variant is 0, `phy_rst_o` is never 1. `ref_out_en_o` rises exactly CLK_MHZ*REF_WAIT_US+1 cycles after `bus_clk_en_o` rises.
- R5: `ep_rst_n_o` stays low for exactly CLK_MHZ*EP_RST_US cycles after the endpoint-reset phase begins, then rises. That phase begins:
  - with the variant at 1, one cycle after `bus_clk_en_o` rises;
  - with the variant at 0, at the edge at which `ref_out_en_o` rises.
- R6: `ltssm_en_o` rises one cycle after `cfg_done_i` is first seen at 1 once `ep_rst_n_o` is high. When it rises, `ep_rst_n_o` is 1 and `phy_rst_o` is 0.
- R7: Polls are CLK_MHZ*POLL_US cycles long, and the first one starts at the edge at which `ltssm_en_o` rises. `link_up_i` is sampled at the end of each poll. If it is 1 at the end of poll k, `done_o` rises k*CLK_MHZ*POLL_US cycles after `ltssm_en_o`.
- R8: If MAX_POLLS polls all end with the link down, `link_fail_o` rises MAX_POLLS*CLK_MHZ*POLL_US cycles after `ltssm_en_o`. `done_o` and `link_fail_o` are never both 1.
- R9: The variant is latched from `split_pwr_i` when start is accepted. Later changes to `split_pwr_i` have no effect on the sequence.
- R10: `start_i` is ignored once a sequence is under way. After `done_o` or `link_fail_o` rises, all outputs hold their values until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request to begin the power-up sequence |
| split_pwr_i | input | 1 | Variant select: 1 means the PHY has a separate power domain |
| cfg_done_i | input | 1 | Controller configuration is complete |
| link_up_i | input | 1 | Link-up status from the controller |
| pwr_en_o | output | 1 | Power-on enable |
| ref_clk_en_o | output | 1 | Reference clock enable |
| bus_clk_en_o | output | 1 | Bus clock enable |
| ref_out_en_o | output | 1 | Reference-clock output enable (shared-power variant only) |
| phy_rst_o | output | 1 | PHY reset, active high |
| ep_rst_n_o | output | 1 | Endpoint reset, active low |
| ltssm_en_o | output | 1 | Link training enable |
| done_o | output | 1 | The link came up |
| link_fail_o | output | 1 | The link never came up within the poll budget |

## Verification
A wrong step in the state register shows up at once as an enable raised out of order, for example a clock enable without power or training enabled while the PHY is still in reset. A wrong load in the shared timer shows up differently. It moves the cycle at which `ref_out_en_o`, `ep_rst_n_o` or `done_o` rises away from its computed position. The bench sweeps both variants, two configuration delays and every poll outcome, and compares the rise cycle of each output against arithmetic on the parameters. A miscount in the poll counter therefore appears as `link_fail_o` one poll early or late, or as a missed `done_o`.

// File: rtl/pcie_rst_seq_pkg.sv
package pcie_rst_seq_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_PWR,
    ST_REFCLK,
    ST_BUSCLK,
    ST_REFWAIT,
    ST_EPRST,
    ST_CFG,
    ST_POLL,
    ST_UP,
    ST_FAIL
  } seq_state_e;

  function automatic int us_to_cycles(input int mhz, input int us);
    return mhz * us;
  endfunction

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/pcie_rst_seq_timer.sv
module pcie_rst_seq_timer #(
  parameter int TW = 17
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [TW-1:0] load_val_i,
  output logic          zero_o
);

  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt_q <= '0;
    else if (load_i)          cnt_q <= load_val_i;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

  // Once expired, the timer stays expired until reloaded (R5, R7)
  p_tmr_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (zero_o && !load_i) |=> zero_o);

endmodule

// File: rtl/pcie_rst_seq_polls.sv
module pcie_rst_seq_polls #(
  parameter int MAX_POLLS = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic inc_i,
  output logic last_o
);

  localparam int PW = $clog2(MAX_POLLS + 1);

  logic [PW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (inc_i)  cnt_q <= cnt_q + 1'b1;
  end

  assign last_o = (cnt_q == PW'(MAX_POLLS - 1));

  // The failed-poll count never reaches the budget; fail is taken first (R8)
  p_poll_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < PW'(MAX_POLLS));

endmodule

// File: rtl/pcie_rst_seq_fsm.sv
module pcie_rst_seq_fsm
  import pcie_rst_seq_pkg::*;
#(
  parameter int TW        = 17,
  parameter int REF_CYC   = 1250,
  parameter int EPRST_CYC = 125000,
  parameter int POLL_CYC  = 12500
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          split_i,
  input  logic          cfg_done_i,
  input  logic          link_up_i,
  input  logic          tmr_zero_i,
  input  logic          poll_last_i,
  output logic          tmr_load_o,
  output logic [TW-1:0] tmr_val_o,
  output logic          poll_clr_o,
  output logic          poll_inc_o,
  output logic          pwr_o,
  output logic          refclk_o,
  output logic          busclk_o,
  output logic          refout_o,
  output logic          phy_rst_o,
  output logic          ep_rst_n_o,
  output logic          ltssm_o,
  output logic          done_o,
  output logic          fail_o
);

  seq_state_e state_q, state_d;
  logic       split_q, split_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      split_q <= 1'b0;
    end else begin
      state_q <= state_d;
      split_q <= split_d;
    end
  end

  always_comb begin
    state_d    = state_q;
    split_d    = split_q;
    tmr_load_o = 1'b0;
    tmr_val_o  = '0;
    poll_clr_o = 1'b0;
    poll_inc_o = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start_i) begin
        state_d = ST_PWR;
        split_d = split_i;
      end
      ST_PWR:    state_d = ST_REFCLK;
      ST_REFCLK: state_d = ST_BUSCLK;
      ST_BUSCLK: begin
        tmr_load_o = 1'b1;
        if (split_q) begin
          state_d   = ST_EPRST;
          tmr_val_o = TW'(EPRST_CYC - 1);
        end else begin
          state_d   = ST_REFWAIT;
          tmr_val_o = TW'(REF_CYC - 1);
        end
      end
      ST_REFWAIT: if (tmr_zero_i) begin
        state_d    = ST_EPRST;
        tmr_load_o = 1'b1;
        tmr_val_o  = TW'(EPRST_CYC - 1);
      end
      ST_EPRST: if (tmr_zero_i) state_d = ST_CFG;
      ST_CFG: if (cfg_done_i) begin
        state_d    = ST_POLL;
        tmr_load_o = 1'b1;
        tmr_val_o  = TW'(POLL_CYC - 1);
        poll_clr_o = 1'b1;
      end
      ST_POLL: if (tmr_zero_i) begin
        if (link_up_i)        state_d = ST_UP;
        else if (poll_last_i) state_d = ST_FAIL;
        else begin
          tmr_load_o = 1'b1;
          tmr_val_o  = TW'(POLL_CYC - 1);
          poll_inc_o = 1'b1;
        end
      end
      ST_UP, ST_FAIL: state_d = state_q;
      default: state_d = ST_IDLE;
    endcase
  end

  // Moore decode of the pin levels from the state
  assign pwr_o      = (state_q != ST_IDLE);
  assign refclk_o   = pwr_o && (state_q != ST_PWR);
  assign busclk_o   = refclk_o && (state_q != ST_REFCLK);
  assign ep_rst_n_o = (state_q inside {ST_CFG, ST_POLL, ST_UP, ST_FAIL});
  assign ltssm_o    = (state_q inside {ST_POLL, ST_UP, ST_FAIL});
  assign refout_o   = !split_q && (state_q == ST_EPRST || ep_rst_n_o);
  assign phy_rst_o  = split_q && pwr_o && !ep_rst_n_o;
  assign done_o     = (state_q == ST_UP);
  assign fail_o     = (state_q == ST_FAIL);

  p_clk_needs_pwr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (refclk_o || busclk_o) |-> pwr_o);

  p_bus_after_ref_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busclk_o) |-> $past(refclk_o));

  p_refout_variant_r3: assert property (@(posedge clk) disable iff (!rst_n)
    refout_o |-> !phy_rst_o);

  p_ltssm_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ltssm_o |-> (ep_rst_n_o && !phy_rst_o));

  p_ltssm_cfg_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ltssm_o) |-> $past(cfg_done_i));

  p_done_link_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> $past(link_up_i));

  p_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && fail_o));

  p_split_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_o && $past(pwr_o)) |-> $stable(split_q));

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o || fail_o) |=> ($stable(done_o) && $stable(fail_o) && ltssm_o));

endmodule

// File: rtl/pcie_rst_seq.sv
module pcie_rst_seq
  import pcie_rst_seq_pkg::*;
#(
  parameter int CLK_MHZ     = 125,
  parameter int REF_WAIT_US = 10,
  parameter int EP_RST_US   = 1000,
  parameter int POLL_US     = 100,
  parameter int MAX_POLLS   = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic split_pwr_i,
  input  logic cfg_done_i,
  input  logic link_up_i,
  output logic pwr_en_o,
  output logic ref_clk_en_o,
  output logic bus_clk_en_o,
  output logic ref_out_en_o,
  output logic phy_rst_o,
  output logic ep_rst_n_o,
  output logic ltssm_en_o,
  output logic done_o,
  output logic link_fail_o
);

  localparam int REF_CYC   = us_to_cycles(CLK_MHZ, REF_WAIT_US);
  localparam int EPRST_CYC = us_to_cycles(CLK_MHZ, EP_RST_US);
  localparam int POLL_CYC  = us_to_cycles(CLK_MHZ, POLL_US);
  localparam int CYC_MAX   = max3(REF_CYC, EPRST_CYC, POLL_CYC);
  localparam int TW        = (CYC_MAX > 1) ? $clog2(CYC_MAX) : 1;

  logic          tmr_load, tmr_zero, poll_clr, poll_inc, poll_last;
  logic [TW-1:0] tmr_val;

  pcie_rst_seq_timer #(.TW(TW)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .zero_o     (tmr_zero)
  );

  pcie_rst_seq_polls #(.MAX_POLLS(MAX_POLLS)) u_polls (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (poll_clr),
    .inc_i  (poll_inc),
    .last_o (poll_last)
  );

  pcie_rst_seq_fsm #(
    .TW        (TW),
    .REF_CYC   (REF_CYC),
    .EPRST_CYC (EPRST_CYC),
    .POLL_CYC  (POLL_CYC)
  ) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .split_i     (split_pwr_i),
    .cfg_done_i  (cfg_done_i),
    .link_up_i   (link_up_i),
    .tmr_zero_i  (tmr_zero),
    .poll_last_i (poll_last),
    .tmr_load_o  (tmr_load),
    .tmr_val_o   (tmr_val),
    .poll_clr_o  (poll_clr),
    .poll_inc_o  (poll_inc),
    .pwr_o       (pwr_en_o),
    .refclk_o    (ref_clk_en_o),
    .busclk_o    (bus_clk_en_o),
    .refout_o    (ref_out_en_o),
    .phy_rst_o   (phy_rst_o),
    .ep_rst_n_o  (ep_rst_n_o),
    .ltssm_o     (ltssm_en_o),
    .done_o      (done_o),
    .fail_o      (link_fail_o)
  );

endmodule

// File: tb/pcie_rst_seq_test.sv
`timescale 1ns/1ps
module pcie_rst_seq_test;

  localparam int MHZ = 2, REF_US = 3, EPR_US = 5, POLL_US = 2, MAXP = 3;
  localparam int R = MHZ * REF_US;
  localparam int P = MHZ * EPR_US;
  localparam int L = MHZ * POLL_US;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start_i = 1'b0, split_pwr_i = 1'b0, cfg_done_i = 1'b0, link_up_i = 1'b0;
  logic pwr_en_o, ref_clk_en_o, bus_clk_en_o, ref_out_en_o, phy_rst_o;
  logic ep_rst_n_o, ltssm_en_o, done_o, link_fail_o;

  int errors = 0, checks = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  pcie_rst_seq #(.CLK_MHZ(MHZ), .REF_WAIT_US(REF_US), .EP_RST_US(EPR_US),
                 .POLL_US(POLL_US), .MAX_POLLS(MAXP)) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .split_pwr_i(split_pwr_i),
    .cfg_done_i(cfg_done_i), .link_up_i(link_up_i), .pwr_en_o(pwr_en_o),
    .ref_clk_en_o(ref_clk_en_o), .bus_clk_en_o(bus_clk_en_o),
    .ref_out_en_o(ref_out_en_o), .phy_rst_o(phy_rst_o), .ep_rst_n_o(ep_rst_n_o),
    .ltssm_en_o(ltssm_en_o), .done_o(done_o), .link_fail_o(link_fail_o));

  task automatic chk(input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  function automatic int outs_vec();
    return {pwr_en_o, ref_clk_en_o, bus_clk_en_o, ref_out_en_o, phy_rst_o,
            ep_rst_n_o, ltssm_en_o, done_o, link_fail_o};
  endfunction

  task automatic do_reset();
    rst_n = 1'b0;
    start_i = 1'b0; cfg_done_i = 1'b0; link_up_i = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R1: idle with start low for a few cycles
    for (int i = 0; i < 3; i++) begin
      @(posedge clk); #1;
      chk("R1 idle outputs", outs_vec(), 0);
    end
  endtask

  // split: variant; d: cycles cfg_done lags; k: poll of link-up (0 = never)
  task automatic run(input bit split, input int d, input int k, input bit poke);
    int b, e, q, t_end, t;
    int r_pwr, r_ref, r_bus, r_out, r_phy_hi, r_phy_lo, r_ep, r_lt, r_done, r_fail;
    string tag;
    tag = $sformatf("[split=%0d d=%0d k=%0d]", split, d, k);
    do_reset();
    b = 3 + (split ? 0 : R);
    e = b + P;
    q = e + d + 1;
    t_end = (k > 0) ? q + k * L : q + MAXP * L;
    r_pwr = -1; r_ref = -1; r_bus = -1; r_out = -1; r_phy_hi = -1; r_phy_lo = -1;
    r_ep = -1; r_lt = -1; r_done = -1; r_fail = -1;
    split_pwr_i = split;
    @(negedge clk) start_i = 1'b1;
    @(posedge clk); #1;
    start_i = 1'b0;
    t = 0;
    while (t <= t_end + 3) begin
      if (r_pwr < 0 && pwr_en_o) r_pwr = t;
      if (r_ref < 0 && ref_clk_en_o) r_ref = t;
      if (r_bus < 0 && bus_clk_en_o) r_bus = t;
      if (r_out < 0 && ref_out_en_o) r_out = t;
      if (r_phy_hi < 0 && phy_rst_o) r_phy_hi = t;
      if (r_phy_hi >= 0 && r_phy_lo < 0 && !phy_rst_o) r_phy_lo = t;
      if (r_ep < 0 && ep_rst_n_o) r_ep = t;
      if (r_lt < 0 && ltssm_en_o) r_lt = t;
      if (r_done < 0 && done_o) r_done = t;
      if (r_fail < 0 && link_fail_o) r_fail = t;
      if (t == e + d) cfg_done_i = 1'b1;
      if (k > 0 && t == q + (k - 1) * L) link_up_i = 1'b1;
      if (poke && t == 1) split_pwr_i = !split;       // R9 stimulus
      if (poke && t == b + 2) start_i = 1'b1;         // R10 stimulus
      if (poke && t == b + 3) start_i = 1'b0;
      if (t == t_end + 1) start_i = 1'b1;             // R10 after outcome
      if (t == t_end + 2) start_i = 1'b0;
      @(posedge clk); #1;
      t++;
    end
    chk({"R2 pwr_en rise ", tag}, r_pwr, 0);
    chk({"R2 ref_clk_en rise ", tag}, r_ref, 1);
    chk({"R2 bus_clk_en rise ", tag}, r_bus, 2);
    chk({"R3/R4 phy_rst first high ", tag}, r_phy_hi, split ? 0 : -1);
    chk({"R3 phy_rst release ", tag}, r_phy_lo, split ? e : -1);
    chk({"R3/R4 ref_out_en rise ", tag}, r_out, split ? -1 : r_bus + R + 1);
    chk({"R5 ep_rst_n rise ", tag}, r_ep, e);
    chk({"R6 ltssm_en rise ", tag}, r_lt, q);
    chk({"R7 done rise ", tag}, r_done, (k > 0) ? q + k * L : -1);
    chk({"R8 link_fail rise ", tag}, r_fail, (k > 0) ? -1 : q + MAXP * L);
    chk({"R10 held after outcome ", tag}, outs_vec(),
        {1'b1, 1'b1, 1'b1, !split, 1'b0, 1'b1, 1'b1, (k > 0), (k == 0)});
    if (poke) chk({"R9 variant latched ", tag}, r_phy_hi, split ? 0 : -1);
  endtask

  initial begin
    do_reset();
    for (int s = 0; s < 2; s++)
      for (int dd = 0; dd < 2; dd++)
        for (int kk = 0; kk <= MAXP; kk++)
          run(s[0], dd * 2, kk, (dd == 1));
    // R1: asynchronous reset in the middle of a sequence
    do_reset();
    split_pwr_i = 1'b1;
    @(negedge clk) start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b0;
    #0.5;
    chk("R1 async reset mid-sequence", outs_vec(), 0);
    @(negedge clk) rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R1 idle after reset release", outs_vec(), 0);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule